// File: doc/BRIEF.md
# LFSR-counter video timing generator

This block produces horizontal sync, vertical sync, a display-enable window and a frame-start strobe from a pixel clock. It does not count pixel and line positions in binary. It tracks them with two 16-bit linear feedback shift registers, one for the pixel within a line and one for the line within a frame. Every stage of such a counter is a single flip-flop fed by a shift or a small XOR, so the counter logic stays shallow at high pixel rates.

Every timing value is written as a code. The code for N steps is the LFSR state reached after stepping N times from the all-ones seed. Software precomputes these codes. The hardware only compares the live state against each code for equality. Equality comparators find the line end, the frame end, and the rising and falling edges of each sync and active window.

An enable input starts the raster at its origin. A two-bit mode input selects one of three behaviours:
- normal video
- blanked video, where the syncs keep running
- power-down, where the syncs are also held inactive

Top module: `vtg_lfsr_timing`

## Requirements
- R1: Position 0 is the seed 16'hFFFF. Each enabled pixel clock moves the horizontal state one step. A step shifts the state left by one, and the new bit 0 is the XOR of the old bits 15, 4, 2 and 1. A window coded as code(n), the state after n steps, therefore opens at pixel n.
- R2: When the horizontal state equals `h_end_code`, the next clock reloads the seed. A line set up with `h_end_code` = code(H-1) is therefore H clocks long.
- R3: The vertical state steps once, at the last pixel of each line. When its next step would equal `v_end_code`, it reloads the seed instead. A frame set up with `v_end_code` = code(V) is therefore V lines long.
- R4: `hsync` is high on the pixels p with a <= p < b, where `hs_start_code` = code(a) and `hs_stop_code` = code(b).
- R5: `vsync` is high on the lines l with a <= l < b, where `vs_start_code` = code(a) and `vs_stop_code` = code(b). A start of line 0 is allowed.
- R6: In mode 2'b00, `de` is high only when the pixel lies in the horizontal active window and the line lies in the vertical active window. Both windows are start-inclusive and stop-exclusive.
- R7: `frame_start` is high for exactly one clock, at pixel 0 of line 0 of each frame.
- R8: Mode 2'b01 (blank) forces `de` low. `hsync`, `vsync` and `frame_start` follow the same pattern as in mode 2'b00.
- R9: Modes 2'b10 and 2'b11 (power-down) hold `hsync`, `vsync` and `de` low while the raster keeps running. `frame_start` still pulses.
- R10: While `enable` is low, all four outputs are low and both states are held at the seed. Raising `enable` starts the raster at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster; low holds it at the origin |
| mode | input | 2 | 00 normal, 01 blank, 10/11 power-down |
| h_end_code | input | 16 | Code of the last pixel of a line, code(H-1) |
| hs_start_code | input | 16 | Code of the first hsync pixel |
| hs_stop_code | input | 16 | Code of the first pixel after hsync |
| hde_start_code | input | 16 | Code of the first horizontally active pixel |
| hde_stop_code | input | 16 | Code of the first pixel after the active span |
| v_end_code | input | 16 | Code of the frame length in lines, code(V) |
| vs_start_code | input | 16 | Code of the first vsync line |
| vs_stop_code | input | 16 | Code of the first line after vsync |
| vde_start_code | input | 16 | Code of the first vertically active line |
| vde_stop_code | input | 16 | Code of the first line after the active span |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| frame_start | output | 1 | One-clock strobe at the frame origin |

## Verification
The assertions and the window logic make three assumptions about the inputs:
- The timing codes stay constant while `enable` is high.
- `enable` stays low for at least one clock after reset and after any code change, so that the window flags can prime themselves for the origin.
- Every window satisfies start < stop <= total-1, and a line is at least two pixels long.

The stimulus writes all codes from a bench-side step function, and only while the raster is stopped. It uses two legal configurations, one with vsync starting at line 0 and one starting later. Each run begins from a disabled raster of at least two clocks.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;

  typedef enum logic [1:0] {
    MODE_SHOW  = 2'b00,
    MODE_BLANK = 2'b01,
    MODE_DARK  = 2'b10,
    MODE_DARK2 = 2'b11
  } vid_mode_e;

  // One left-shift step of a Fibonacci LFSR of up to 32 bits.
  function automatic logic [31:0] lfsr_next(input logic [31:0] cur,
                                            input logic [31:0] taps,
                                            input int unsigned width);
    logic [31:0] mask;
    logic        fb;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    fb   = ^(cur & taps & mask);
    return ((cur << 1) | {31'd0, fb}) & mask;
  endfunction

endpackage

// File: rtl/vtg_lfsr_axis.sv
module vtg_lfsr_axis #(
  parameter int unsigned    W          = 16,
  parameter logic [W-1:0]   TAPS       = W'('h8016),
  parameter logic [W-1:0]   SEED       = '1,
  parameter bit             WRAP_AHEAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         adv,
  input  logic [W-1:0] end_code,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] stepped;
  logic [31:0]  step32;
  logic         at_end;

  assign step32  = lfsr_vtg_pkg::lfsr_next(32'(state_q), 32'(TAPS), W);
  assign stepped = step32[W-1:0];

  generate
    if (WRAP_AHEAD) begin : g_ahead
      // the end code itself is never held: reload instead of reaching it
      assign at_end = (stepped == end_code);
    end else begin : g_here
      // the end code is the last held position
      assign at_end = (state_q == end_code);
    end
  endgenerate

  assign next_o  = at_end ? SEED : stepped;
  assign wrap_o  = run & adv & at_end;
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= SEED;
    else if (!run)   state_q <= SEED;
    else if (adv)    state_q <= next_o;
  end

endmodule

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         adv,
  input  logic [W-1:0] pos_next,
  input  logic [W-1:0] start_code,
  input  logic [W-1:0] stop_code,
  output logic         active_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (!run) begin
      // prime for the origin so a window opening at step 0 is seen at once
      flag_q <= (start_code == SEED) && (stop_code != SEED);
    end else if (adv) begin
      if (pos_next == stop_code)       flag_q <= 1'b0;
      else if (pos_next == start_code) flag_q <= 1'b1;
    end
  end

  assign active_o = flag_q;

endmodule

// File: rtl/vtg_lfsr_timing.sv
module vtg_lfsr_timing #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] TAPS = W'('h8016),
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [1:0]   mode,
  input  logic [W-1:0] h_end_code,
  input  logic [W-1:0] hs_start_code,
  input  logic [W-1:0] hs_stop_code,
  input  logic [W-1:0] hde_start_code,
  input  logic [W-1:0] hde_stop_code,
  input  logic [W-1:0] v_end_code,
  input  logic [W-1:0] vs_start_code,
  input  logic [W-1:0] vs_stop_code,
  input  logic [W-1:0] vde_start_code,
  input  logic [W-1:0] vde_stop_code,
  output logic         hsync,
  output logic         vsync,
  output logic         de,
  output logic         frame_start
);
  import lfsr_vtg_pkg::*;

  localparam int unsigned NWIN     = 2;  // per axis: sync, active
  localparam int unsigned WIN_SYNC = 0;
  localparam int unsigned WIN_ACT  = 1;

  // named internal events (observed by the bound checker)
  logic [W-1:0] h_state, h_next;
  logic [W-1:0] v_state, v_next;
  logic         h_wrap, v_wrap;
  logic [NWIN-1:0] h_win, v_win;

  logic [W-1:0] h_start [NWIN];
  logic [W-1:0] h_stop  [NWIN];
  logic [W-1:0] v_start [NWIN];
  logic [W-1:0] v_stop  [NWIN];

  assign h_start[WIN_SYNC] = hs_start_code;
  assign h_stop [WIN_SYNC] = hs_stop_code;
  assign h_start[WIN_ACT]  = hde_start_code;
  assign h_stop [WIN_ACT]  = hde_stop_code;
  assign v_start[WIN_SYNC] = vs_start_code;
  assign v_stop [WIN_SYNC] = vs_stop_code;
  assign v_start[WIN_ACT]  = vde_start_code;
  assign v_stop [WIN_ACT]  = vde_stop_code;

  vtg_lfsr_axis #(.W(W), .TAPS(TAPS), .SEED(SEED), .WRAP_AHEAD(1'b0)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .run(enable), .adv(1'b1),
    .end_code(h_end_code), .state_o(h_state), .next_o(h_next), .wrap_o(h_wrap)
  );

  vtg_lfsr_axis #(.W(W), .TAPS(TAPS), .SEED(SEED), .WRAP_AHEAD(1'b1)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .run(enable), .adv(h_wrap),
    .end_code(v_end_code), .state_o(v_state), .next_o(v_next), .wrap_o(v_wrap)
  );

  generate
    for (genvar i = 0; i < NWIN; i++) begin : g_win
      vtg_window #(.W(W), .SEED(SEED)) u_hw (
        .clk(clk), .rst_n(rst_n), .run(enable), .adv(1'b1),
        .pos_next(h_next), .start_code(h_start[i]), .stop_code(h_stop[i]),
        .active_o(h_win[i])
      );
      vtg_window #(.W(W), .SEED(SEED)) u_vw (
        .clk(clk), .rst_n(rst_n), .run(enable), .adv(h_wrap),
        .pos_next(v_next), .start_code(v_start[i]), .stop_code(v_stop[i]),
        .active_o(v_win[i])
      );
    end
  endgenerate

  vid_mode_e mode_e;
  logic      syncs_on, pixels_on, at_origin;

  assign mode_e    = vid_mode_e'(mode);
  assign syncs_on  = enable && (mode_e == MODE_SHOW || mode_e == MODE_BLANK);
  assign pixels_on = enable && (mode_e == MODE_SHOW);
  assign at_origin = (h_state == SEED) && (v_state == SEED);

  assign hsync       = syncs_on  & h_win[WIN_SYNC];
  assign vsync       = syncs_on  & v_win[WIN_SYNC];
  assign de          = pixels_on & h_win[WIN_ACT] & v_win[WIN_ACT];
  assign frame_start = enable & at_origin;

endmodule

// File: rtl/vtg_lfsr_checker.sv
module vtg_lfsr_checker #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] TAPS = W'('h8016),
  parameter logic [W-1:0] SEED = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic [1:0]   mode,
  input logic [W-1:0] h_end_code,
  input logic [W-1:0] h_state,
  input logic [W-1:0] v_state,
  input logic         v_wrap,
  input logic         hsync,
  input logic         vsync,
  input logic         de,
  input logic         frame_start
);

  logic [31:0] h_step32;
  assign h_step32 = lfsr_vtg_pkg::lfsr_next(32'(h_state), 32'(TAPS), W);

  p_h_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && h_state != h_end_code) |=> (32'(h_state) == $past(h_step32)));

  p_h_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && h_state == h_end_code) |=> (h_state == SEED));

  p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && h_state != h_end_code) |=> $stable(v_state));

  p_v_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |=> (v_state == SEED));

  p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && h_end_code != SEED) |=> !frame_start);

  p_blank_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !de);

  p_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (!hsync && !vsync && !de));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!hsync && !vsync && !de && !frame_start));

  p_off_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (h_state == SEED && v_state == SEED));

endmodule

bind vtg_lfsr_timing vtg_lfsr_checker #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
  .h_end_code(h_end_code), .h_state(h_state), .v_state(v_state), .v_wrap(v_wrap),
  .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start)
);

// File: tb/tb_vtg_lfsr_timing.sv
`timescale 1ns/1ps
module tb_vtg_lfsr_timing;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] h_end_code = '0, hs_start_code = '0, hs_stop_code = '0;
  logic [W-1:0] hde_start_code = '0, hde_stop_code = '0, v_end_code = '0;
  logic [W-1:0] vs_start_code = '0, vs_stop_code = '0;
  logic [W-1:0] vde_start_code = '0, vde_stop_code = '0;
  logic hsync, vsync, de, frame_start;

  always #5 clk = ~clk;

  vtg_lfsr_timing dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .h_end_code(h_end_code), .hs_start_code(hs_start_code), .hs_stop_code(hs_stop_code),
    .hde_start_code(hde_start_code), .hde_stop_code(hde_stop_code),
    .v_end_code(v_end_code), .vs_start_code(vs_start_code), .vs_stop_code(vs_stop_code),
    .vde_start_code(vde_start_code), .vde_stop_code(vde_stop_code),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start)
  );

  typedef struct {
    logic  hs, vs, de, fs;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0, n_fail = 0;
  int c_h, c_hs0, c_hs1, c_hd0, c_hd1, c_v, c_vs0, c_vs1, c_vd0, c_vd1;

  // code for n steps: shift left, feedback = b15^b4^b2^b1, from all ones
  function automatic logic [15:0] code_of(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input int p, input int l, input logic [1:0] m, input string tag);
    exp_t e;
    e.hs  = (p >= c_hs0 && p < c_hs1) && !m[1];
    e.vs  = (l >= c_vs0 && l < c_vs1) && !m[1];
    e.de  = (p >= c_hd0 && p < c_hd1) && (l >= c_vd0 && l < c_vd1) && (m == 2'b00);
    e.fs  = (p == 0 && l == 0);
    e.tag = tag;
    return e;
  endfunction

  // monitor: pops one expectation per cycle, sampled at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && sb.size() > 0) begin
      e = sb.pop_front();
      check(hsync === e.hs, e.tag, "hsync (R4)", int'(hsync), int'(e.hs));
      check(vsync === e.vs, e.tag, "vsync (R5)", int'(vsync), int'(e.vs));
      check(de === e.de, e.tag, "de (R6)", int'(de), int'(e.de));
      check(frame_start === e.fs, e.tag, "frame_start (R7)", int'(frame_start), int'(e.fs));
    end
  end

  task automatic configure(input int h, input int hs0, input int hs1, input int hd0, input int hd1,
                           input int v, input int vs0, input int vs1, input int vd0, input int vd1);
    c_h = h; c_hs0 = hs0; c_hs1 = hs1; c_hd0 = hd0; c_hd1 = hd1;
    c_v = v; c_vs0 = vs0; c_vs1 = vs1; c_vd0 = vd0; c_vd1 = vd1;
    h_end_code = code_of(h - 1);
    hs_start_code = code_of(hs0);  hs_stop_code = code_of(hs1);
    hde_start_code = code_of(hd0); hde_stop_code = code_of(hd1);
    v_end_code = code_of(v);
    vs_start_code = code_of(vs0);  vs_stop_code = code_of(vs1);
    vde_start_code = code_of(vd0); vde_stop_code = code_of(vd1);
  endtask

  // driver: start the raster, queue ncyc expected cycles, then stop (R10)
  task automatic run_span(input logic [1:0] m, input int ncyc, input string tag);
    exp_t z;
    @(posedge clk); #1;
    mode = m; enable = 1'b1;
    for (int k = 0; k < ncyc; k++) sb.push_back(model(k % c_h, (k / c_h) % c_v, m, tag));
    wait (sb.size() == 0);
    @(posedge clk); #1;
    enable = 1'b0;
    z.hs = 0; z.vs = 0; z.de = 0; z.fs = 0; z.tag = "R10";
    for (int k = 0; k < 2; k++) sb.push_back(z);
    wait (sb.size() == 0);
  endtask

  // line length (R2), frame length (R3), first hsync edge (R1)
  task automatic measure();
    int fs1, fs2, hr1, hr2;
    logic prev_hs;
    fs1 = -1; fs2 = -1; hr1 = -1; hr2 = -1; prev_hs = 1'b0;
    @(posedge clk); #1;
    mode = 2'b00; enable = 1'b1;
    for (int k = 0; k < 2 * c_h * c_v + 2; k++) begin
      @(negedge clk);
      if (frame_start) begin
        if (fs1 < 0) fs1 = k; else if (fs2 < 0) fs2 = k;
      end
      if (hsync && !prev_hs) begin
        if (hr1 < 0) hr1 = k; else if (hr2 < 0) hr2 = k;
      end
      prev_hs = hsync;
    end
    @(posedge clk); #1;
    enable = 1'b0;
    check(hr1 == c_hs0, "R1", "first hsync rise pixel", hr1, c_hs0);
    check(hr2 - hr1 == c_h, "R2", "line length", hr2 - hr1, c_h);
    check(fs2 - fs1 == c_h * c_v, "R3", "frame length", fs2 - fs1, c_h * c_v);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    configure(10, 1, 3, 4, 9, 6, 0, 2, 2, 5);
    repeat (3) @(posedge clk);
    #1;
    check(!hsync && !vsync && !de && !frame_start, "R10", "outputs in reset",
          int'({hsync, vsync, de, frame_start}), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(!hsync && !vsync && !de && !frame_start, "R10", "outputs idle after reset",
          int'({hsync, vsync, de, frame_start}), 0);

    run_span(2'b00, 2 * 60, "R6");
    run_span(2'b01, 60, "R8");
    run_span(2'b10, 60, "R9");
    run_span(2'b11, 60, "R9");
    run_span(2'b00, 33, "R10");   // stop mid-frame
    run_span(2'b00, 60, "R10");   // restart from origin
    measure();

    configure(7, 1, 2, 2, 6, 5, 1, 3, 1, 4);
    run_span(2'b00, 2 * 35, "R6");
    run_span(2'b01, 35, "R8");
    run_span(2'b10, 35, "R9");
    measure();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule